// File: doc/BRIEF.md
# Serial Indexed Register Port

This block is a clock-synchronous serial slave that gives a host access to a bank of 16-bit control registers. The serial pins are chip-select (active low), a serial clock and one data line in each direction. The block samples them with the system clock. A transfer opens when chip-select falls. A header byte comes first. It chooses between the index register and the register the index points to, and between a read and a write.

A header with the select bit low addresses the index register. A header with the select bit high addresses the register the index currently points to. Any write of the exact three-value sequence 0x0006, 0x000E, 0x0000 to register 0x28 restores every register to its power-on default and clears the index to 0.

Top module: `sreg_port`

## Requirements
- R1: The header is 8 bits, MSB first: bits 7..2 must equal 6'b011100, bit 1 is the select bit (0 = index, 1 = pointed register) and bit 0 is the direction (1 = read, 0 = write). Data follows as 16 bits, MSB first. All input bits are taken on the rising edge of the serial clock.
- R2: A write with select 0 loads the index from the data word. A word of 0x0080 or above loads 0x7F.
- R3: A write with select 1 stores the word in the register at the current index, and a later read returns it. This includes the top implemented index 0x7D.
- R4: On a read, the 16 data bits leave MSB first on the data output, which changes after falling serial-clock edges. The output is 0 while chip-select is high.
- R5: A read with select 0 returns the index, zero-extended to 16 bits.
- R6: When the header prefix does not match, the rest of the transfer is ignored: nothing is written and the data output stays 0.
- R7: After the asynchronous reset, the index is 0 and register k reads {1'b0, k[6:0], 8'hC3}. Register 0x28 is the exception.
- R8: Indexes 0x7E, 0x7F and 0x28 read as 0, and writes to them have no effect.
- R9: After the writes 0x0006, 0x000E, 0x0000 to register 0x28, in that order, all registers return to their R7 defaults and the index returns to 0.
- R10: Any other write to register 0x28 sends the sequence back to its start, so no reset follows. A write of 0x0006 always counts as the first step of a new sequence.
- R11: When chip-select rises before all 24 bits have arrived, the transfer is abandoned without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csb_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
A single write commit can do three things in the same cycle: store a value, break the reset sequence, and begin a new one. The bench provokes this with the series 6, E, 6, E, 0 to register 0x28. The third write has to abandon the sequence in progress and also count as its first step. A default read-back from a register that was changed earlier confirms that the restore took place. The series 6, E, 5, 0 is also sent, and there a survivor value has to remain unchanged.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int DW       = 16;
  localparam int IDX_W    = 7;
  localparam int NUM_REGS = 126;
  localparam logic [IDX_W-1:0] SRST_IDX = 7'h28;
  localparam logic [5:0] HDR_PREFIX = 6'b011100;
  localparam logic [DW-1:0] SEQ_A = 16'h0006;
  localparam logic [DW-1:0] SEQ_B = 16'h000E;
  localparam logic [DW-1:0] SEQ_C = 16'h0000;

  typedef enum logic [1:0] {FS_IDLE, FS_HDR, FS_DATA, FS_DONE} fstate_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_GOT_A, SQ_GOT_B} sqstate_e;

  function automatic logic [DW-1:0] reg_default(input int k);
    logic [IDX_W-1:0] kk;
    kk = IDX_W'(k);
    return {1'b0, kk, 8'hC3};
  endfunction
endpackage

// File: rtl/sreg_frontend.sv
module sreg_frontend
  import sreg_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csb_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_reg_i,
  input  logic [DATA_W-1:0] rd_idx_i,
  output logic              wr_stb_o,
  output logic              wr_sel_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic csb_m, csb_s, sck_m, sck_s, sck_q, sdi_m, sdi_s;
  logic sck_rise, sck_fall;
  fstate_e st;
  logic [CNT_W-1:0] cnt;
  logic [6:0] hsh;
  logic [DATA_W-1:0] dsh, rsh;
  logic sel_q, rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csb_m <= 1'b1; csb_s <= 1'b1;
      sck_m <= 1'b0; sck_s <= 1'b0; sck_q <= 1'b0;
      sdi_m <= 1'b0; sdi_s <= 1'b0;
    end else begin
      csb_m <= csb_i; csb_s <= csb_m;
      sck_m <= sck_i; sck_s <= sck_m; sck_q <= sck_s;
      sdi_m <= sdi_i; sdi_s <= sdi_m;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= FS_IDLE; cnt <= '0; hsh <= '0; dsh <= '0; rsh <= '0;
      sel_q <= 1'b0; rw_q <= 1'b0;
      wr_stb_o <= 1'b0; wr_data_o <= '0; sdo_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      if (csb_s) begin
        st <= FS_IDLE; cnt <= '0; sdo_o <= 1'b0;
      end else begin
        unique case (st)
          FS_IDLE: begin st <= FS_HDR; cnt <= '0; end
          FS_HDR: if (sck_rise) begin
            hsh <= {hsh[5:0], sdi_s};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(7)) begin
              cnt <= '0;
              if (hsh[6:1] == HDR_PREFIX) begin
                st    <= FS_DATA;
                sel_q <= hsh[0];
                rw_q  <= sdi_s;
                rsh   <= hsh[0] ? rd_reg_i : rd_idx_i;
              end else begin
                st <= FS_DONE;
              end
            end
          end
          FS_DATA: begin
            if (sck_rise) begin
              dsh <= {dsh[DATA_W-2:0], sdi_s};
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(DATA_W-1)) begin
                st <= FS_DONE;
                if (!rw_q) begin
                  wr_stb_o  <= 1'b1;
                  wr_data_o <= {dsh[DATA_W-2:0], sdi_s};
                end
              end
            end else if (sck_fall && rw_q) begin
              sdo_o <= rsh[DATA_W-1];
              rsh   <= {rsh[DATA_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_sel_o = sel_q;

  a_r4_sdo_low_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csb_s) |=> !sdo_o);
  a_r11_wr_only_while_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> !$past(csb_s));
  a_r1_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/sreg_srst_seq.sv
module sreg_srst_seq
  import sreg_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              srst_o
);
  sqstate_e st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= SQ_IDLE; srst_o <= 1'b0;
    end else begin
      srst_o <= 1'b0;
      if (wr_i) begin
        if (data_i == SEQ_A)                       st <= SQ_GOT_A;
        else if (st == SQ_GOT_A && data_i == SEQ_B) st <= SQ_GOT_B;
        else begin
          st <= SQ_IDLE;
          if (st == SQ_GOT_B && data_i == SEQ_C) srst_o <= 1'b1;
        end
      end
    end
  end

  a_r9_srst_follows_final_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |-> $past(wr_i && data_i == SEQ_C));
  a_r10_srst_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !srst_o);
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = IDX_W,
  parameter int N_REGS = NUM_REGS,
  parameter logic [ADDR_W-1:0] HOLE = SRST_IDX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_REGS - 1);
  logic [DATA_W-1:0] regs [N_REGS];

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    if (ADDR_W'(k) == HOLE) begin : g_hole
      assign regs[k] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  regs[k] <= DATA_W'(reg_default(k));
        else if (srst_i)                              regs[k] <= DATA_W'(reg_default(k));
        else if (we_i && addr_i == ADDR_W'(k))        regs[k] <= wdata_i;
      end
    end
  end

  assign rdata_o = (addr_i <= LAST) ? regs[addr_i] : '0;

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && !srst_i && addr_i <= LAST && addr_i != HOLE) && $stable(addr_i)
      |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csb_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o
);
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0] bank_rdata, wr_data;
  logic wr_stb, wr_sel, srst, wr_reg, wr_seq;

  sreg_frontend #(.DATA_W(DW)) u_front (
    .clk_i, .rst_ni, .csb_i, .sck_i, .sdi_i,
    .rd_reg_i (bank_rdata),
    .rd_idx_i ({{(DW-IDX_W){1'b0}}, idx_q}),
    .wr_stb_o (wr_stb),
    .wr_sel_o (wr_sel),
    .wr_data_o(wr_data),
    .sdo_o
  );

  assign wr_reg = wr_stb & wr_sel;
  assign wr_seq = wr_reg & (idx_q == SRST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (srst)              idx_q <= '0;
    else if (wr_stb && !wr_sel) idx_q <= (|wr_data[DW-1:IDX_W]) ? '1 : wr_data[IDX_W-1:0];
  end

  sreg_srst_seq #(.DATA_W(DW)) u_seq (
    .clk_i, .rst_ni, .wr_i(wr_seq), .data_i(wr_data), .srst_o(srst)
  );

  sreg_bank #(.DATA_W(DW), .ADDR_W(IDX_W), .N_REGS(NUM_REGS), .HOLE(SRST_IDX)) u_bank (
    .clk_i, .rst_ni, .srst_i(srst), .we_i(wr_reg), .addr_i(idx_q),
    .wdata_i(wr_data), .rdata_o(bank_rdata)
  );

  a_r9_index_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst) |-> idx_q == '0);
  a_r2_index_only_on_sel0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(srst) && !($past(wr_stb) && !$past(wr_sel)) |-> $stable(idx_q));
endmodule

// File: tb/sreg_port_bench.sv
module sreg_port_bench;
  logic clk = 1'b0, rst_n = 1'b0, csb = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  int n_chk = 0, n_fail = 0;
  localparam logic [5:0] PFX = 6'b011100;

  always #4 clk = ~clk;

  sreg_port u_sreg_port (.clk_i(clk), .rst_ni(rst_n), .csb_i(csb), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [5:0] pfx, input logic sel, input logic rw,
                      input logic [15:0] data, input int nbits, output logic [15:0] rd);
    logic [23:0] frame;
    frame = {pfx, sel, rw, data};
    rd = '0;
    @(negedge clk); csb = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; sdi = frame[23-i];
      wait_clk(4);
      if (i >= 8) rd = {rd[14:0], sdo};
      sck = 1'b1;
      wait_clk(4);
    end
    sck = 1'b0;
    wait_clk(4);
    csb = 1'b1;
    wait_clk(6);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    logic [15:0] dummy;
    xfer(PFX, sel, 1'b0, d, 24, dummy);
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    xfer(PFX, sel, 1'b1, 16'h0000, 24, v);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R4 idle sdo", {15'b0, sdo}, 16'h0000);
    rd(1'b0, v);  check("R7 index after reset", v, 16'h0000);
    rd(1'b1, v);  check("R7 reg 0x00 default", v, 16'h00C3);
    wr(1'b0, 16'h0010);
    rd(1'b1, v);  check("R7 R1 reg 0x10 default", v, 16'h10C3);
  endtask

  task automatic t_index;
    logic [15:0] v;
    wr(1'b0, 16'h0012); rd(1'b0, v); check("R2 R5 index write", v, 16'h0012);
    wr(1'b0, 16'h0180); rd(1'b0, v); check("R2 index clamp", v, 16'h007F);
  endtask

  task automatic t_reg_rw;
    logic [15:0] v;
    wr(1'b0, 16'h0012); wr(1'b1, 16'hA55A);
    rd(1'b1, v); check("R3 R4 reg 0x12 readback", v, 16'hA55A);
    wr(1'b0, 16'h007D); wr(1'b1, 16'h1234);
    rd(1'b1, v); check("R3 reg 0x7D readback", v, 16'h1234);
  endtask

  task automatic t_unimpl;
    logic [15:0] v;
    wr(1'b0, 16'h007E); wr(1'b1, 16'hFFFF);
    rd(1'b1, v); check("R8 index 0x7E reads zero", v, 16'h0000);
    wr(1'b0, 16'h0028); wr(1'b1, 16'h0123);
    rd(1'b1, v); check("R8 index 0x28 reads zero", v, 16'h0000);
  endtask

  task automatic t_bad_prefix;
    logic [15:0] v;
    wr(1'b0, 16'h0012);
    xfer(6'b111111, 1'b1, 1'b0, 16'h0000, 24, v);
    xfer(6'b011101, 1'b0, 1'b0, 16'h0005, 24, v);
    rd(1'b0, v); check("R6 index untouched", v, 16'h0012);
    rd(1'b1, v); check("R6 reg untouched", v, 16'hA55A);
    xfer(6'b111100, 1'b1, 1'b1, 16'h0000, 24, v);
    check("R6 sdo silent on bad read", v, 16'h0000);
  endtask

  task automatic t_abort;
    logic [15:0] v;
    xfer(PFX, 1'b1, 1'b0, 16'h0000, 16, v);
    rd(1'b1, v); check("R11 short write dropped", v, 16'hA55A);
  endtask

  task automatic t_soft_reset;
    logic [15:0] v;
    wr(1'b0, 16'h0028);
    wr(1'b1, 16'h0006); wr(1'b1, 16'h000E); wr(1'b1, 16'h0005); wr(1'b1, 16'h0000);
    wr(1'b1, 16'h0006); wr(1'b1, 16'h0000);
    rd(1'b0, v); check("R10 broken order keeps index", v, 16'h0028);
    wr(1'b0, 16'h0012);
    rd(1'b1, v); check("R10 broken order keeps reg", v, 16'hA55A);
    wr(1'b0, 16'h0028);
    wr(1'b1, 16'h0006); wr(1'b1, 16'h000E); wr(1'b1, 16'h0006);
    wr(1'b1, 16'h000E); wr(1'b1, 16'h0000);
    rd(1'b0, v); check("R9 index cleared", v, 16'h0000);
    wr(1'b0, 16'h0012);
    rd(1'b1, v); check("R9 R10 reg 0x12 default restored", v, 16'h12C3);
    wr(1'b0, 16'h007D);
    rd(1'b1, v); check("R9 reg 0x7D default restored", v, 16'h7DC3);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_index();
    t_reg_rw();
    t_unimpl();
    t_bad_prefix();
    t_abort();
    t_soft_reset();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule